// File: doc/BRIEF.md
# ADC Auto-Calibration Statistics Engine

This block sits on a 24-bit RGB pixel stream that arrives with its pixel clock, horizontal sync, vertical sync and data-enable. For every frame it collects the figures that firmware needs to tune an analogue-to-digital front end and to centre the picture. For each colour it finds the lowest and highest value inside a programmable window, and it counts the pixels that fall below and above a programmable level. It captures one pixel at a chosen coordinate. It sums the absolute differences between horizontally neighbouring pixels on one channel, and a larger sum means a better sampling phase. It also measures where the non-black picture starts and how far it extends, both horizontally and vertically.

All statistics accumulate during a frame. At the next vertical sync leading edge they are copied into a read-side register set and the accumulators restart, so a read always returns the figures of one whole frame. A sticky flag shows that a fresh set has arrived, and reading the status word clears it.

Top module: `calstat_top`

## Requirements
- R1: For each of R, G and B, the minimum and maximum over pixels that have data-enable high and lie inside the window (win_x0 <= x <= win_x1, win_y0 <= y <= win_y1) are reported. With no such pixel, the minimum reads 0xFF and the maximum reads 0x00. Words pack red in bits 7:0, green in bits 15:8 and blue in bits 23:16.
- R2: For each colour, the windowed pixels whose value is strictly below hist_thr are counted, and separately those strictly above it. A value equal to hist_thr is counted in neither.
- R3: The grab word holds {B,G,R} of the one data-enable pixel at (grab_x, grab_y). If no such pixel occurs in the frame, it reads 0.
- R4: The pixel x coordinate is the number of clocks since the first clock with hsync low after a high period, so that pixel is x = 0. The y coordinate is the number of hsync rising edges since vsync fell, and the line on which vsync falls is y = 0. Pixels with data-enable low take part in no statistic.
- R5: A pixel is non-black when it has data-enable high and any channel is above black_thr. The horizontal back porch is the smallest x of a non-black pixel in the frame, and the horizontal active size is the largest such x + 1 minus that back porch. Both read 0 if the frame has no non-black pixel.
- R6: The vertical back porch and the vertical active size follow R5 with y in place of x.
- R7: The phase sum adds |v(x) - v(x-1)| over each pair of windowed pixels on consecutive clocks of one line. v is the channel chosen by phase_sel: 0 = R, 1 = G, 2 or 3 = B.
- R8: The phase sum saturates at 2^PH_W - 1 and does not wrap.
- R9: All accumulators clear at each vsync rising edge, and the read-side registers load the finished frame's results on that same edge. Between two such edges, the read values do not change.
- R10: Status bit 0 is a done flag. It sets on each vsync rising edge and clears on a clock where rd_en is high with rd_addr = 0.
- R11: After reset, every readable address returns 0.
- R12: The read map is as follows. 0 holds status. 1 holds the minima and 2 the maxima. 3 and 4 hold the red below and above counts, 5 and 6 the green ones, and 7 and 8 the blue ones. 9 holds the grab word and 10 the phase sum. 11 and 12 hold the horizontal porch and active size, and 13 and 14 the vertical ones. 15 reads 0. rd_data depends on rd_addr without a clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | pixel clock |
| rst_n | input | 1 | asynchronous active-low reset |
| pix_de | input | 1 | data-enable for the current pixel |
| hsync | input | 1 | horizontal sync, active high |
| vsync | input | 1 | vertical sync, active high |
| pix_r | input | 8 | red sample |
| pix_g | input | 8 | green sample |
| pix_b | input | 8 | blue sample |
| win_x0 | input | X_W | window left column |
| win_x1 | input | X_W | window right column |
| win_y0 | input | Y_W | window top line |
| win_y1 | input | Y_W | window bottom line |
| hist_thr | input | 8 | histogram level |
| black_thr | input | 8 | level above which a channel is non-black |
| phase_sel | input | 2 | channel used for the phase sum |
| grab_x | input | X_W | grab column |
| grab_y | input | Y_W | grab line |
| rd_en | input | 1 | read strobe (clears done when rd_addr is 0) |
| rd_addr | input | 4 | read address |
| rd_data | output | 32 | read data |

## Verification
A wrong coordinate counter shifts every windowed figure together: the grab word, the porch values and the min/max words all go wrong in the first frame read after the fault. If the data-enable gate is missing, the 0xEE filler driven during blanking leaks into the maximum and the porch words at once. A missing clear or a missing saturation shows in the phase and count words one frame later. A done flag that is stuck shows on the very next status read. Each frame's figures are checked halfway through the following frame, and the phase word is read again later in that frame to confirm it holds still.

// File: rtl/calstat_pkg.sv
package calstat_pkg;
  localparam logic [3:0] RA_STATUS = 4'd0;
  localparam logic [3:0] RA_MIN    = 4'd1;
  localparam logic [3:0] RA_MAX    = 4'd2;
  localparam logic [3:0] RA_RLO    = 4'd3;
  localparam logic [3:0] RA_RHI    = 4'd4;
  localparam logic [3:0] RA_GLO    = 4'd5;
  localparam logic [3:0] RA_GHI    = 4'd6;
  localparam logic [3:0] RA_BLO    = 4'd7;
  localparam logic [3:0] RA_BHI    = 4'd8;
  localparam logic [3:0] RA_GRAB   = 4'd9;
  localparam logic [3:0] RA_PHASE  = 4'd10;
  localparam logic [3:0] RA_HBP    = 4'd11;
  localparam logic [3:0] RA_HACT   = 4'd12;
  localparam logic [3:0] RA_VBP    = 4'd13;
  localparam logic [3:0] RA_VACT   = 4'd14;

  localparam int unsigned NCH = 3;

  typedef enum logic [1:0] {
    CH_RED  = 2'd0,
    CH_GRN  = 2'd1,
    CH_BLU  = 2'd2,
    CH_BLU2 = 2'd3
  } chan_sel_e;
endpackage

// File: rtl/calstat_timing.sv
module calstat_timing #(
  parameter int X_W = 12,
  parameter int Y_W = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hsync,
  input  logic           vsync,
  output logic [X_W-1:0] pos_x,
  output logic [Y_W-1:0] pos_y,
  output logic           frame_start
);
  logic           hs_q, vs_q;
  logic [X_W-1:0] x_q, x_d;
  logic [Y_W-1:0] y_q, y_d;
  logic           hs_fall, hs_rise, vs_fall;

  always_comb begin
    hs_fall     = hs_q & ~hsync;
    hs_rise     = hsync & ~hs_q;
    vs_fall     = vs_q & ~vsync;
    frame_start = vsync & ~vs_q;
    pos_x       = hs_fall ? '0 : x_q;
    pos_y       = y_q;
    x_d         = (&pos_x) ? pos_x : pos_x + X_W'(1);
    if (vs_fall)                y_d = '0;
    else if (hs_rise && !(&y_q)) y_d = y_q + Y_W'(1);
    else                        y_d = y_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q <= 1'b0;
      vs_q <= 1'b0;
      x_q  <= '1;
      y_q  <= '1;
    end else begin
      hs_q <= hsync;
      vs_q <= vsync;
      x_q  <= x_d;
      y_q  <= y_d;
    end
  end
endmodule

// File: rtl/calstat_chan.sv
module calstat_chan #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             take,
  input  logic [7:0]       thr,
  input  logic [7:0]       val,
  output logic [7:0]       vmin,
  output logic [7:0]       vmax,
  output logic [CNT_W-1:0] n_lo,
  output logic [CNT_W-1:0] n_hi
);
  logic             en;
  logic [7:0]       min_d, max_d;
  logic [CNT_W-1:0] lo_d, hi_d;

  always_comb begin
    en    = clr | take;
    min_d = 8'hFF;
    max_d = 8'h00;
    lo_d  = '0;
    hi_d  = '0;
    if (!clr) begin
      min_d = (val < vmin) ? val : vmin;
      max_d = (val > vmax) ? val : vmax;
      lo_d  = (val < thr) ? n_lo + CNT_W'(1) : n_lo;
      hi_d  = (val > thr) ? n_hi + CNT_W'(1) : n_hi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vmin <= 8'hFF;
      vmax <= 8'h00;
      n_lo <= '0;
      n_hi <= '0;
    end else if (en) begin
      vmin <= min_d;
      vmax <= max_d;
      n_lo <= lo_d;
      n_hi <= hi_d;
    end
  end
endmodule

// File: rtl/calstat_extent.sv
module calstat_extent #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         hit,
  input  logic [W-1:0] pos,
  output logic         seen,
  output logic [W-1:0] lo,
  output logic [W-1:0] hi
);
  logic         en, seen_d;
  logic [W-1:0] lo_d, hi_d;

  always_comb begin
    en     = clr | hit;
    seen_d = ~clr;
    lo_d   = clr ? '1 : ((pos < lo) ? pos : lo);
    hi_d   = clr ? '0 : ((pos > hi) ? pos : hi);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen <= 1'b0;
      lo   <= '1;
      hi   <= '0;
    end else if (en) begin
      seen <= seen_d;
      lo   <= lo_d;
      hi   <= hi_d;
    end
  end
endmodule

// File: rtl/calstat_top.sv
module calstat_top
  import calstat_pkg::*;
#(
  parameter int X_W   = 12,
  parameter int Y_W   = 12,
  parameter int CNT_W = 20,
  parameter int PH_W  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pix_de,
  input  logic           hsync,
  input  logic           vsync,
  input  logic [7:0]     pix_r,
  input  logic [7:0]     pix_g,
  input  logic [7:0]     pix_b,
  input  logic [X_W-1:0] win_x0,
  input  logic [X_W-1:0] win_x1,
  input  logic [Y_W-1:0] win_y0,
  input  logic [Y_W-1:0] win_y1,
  input  logic [7:0]     hist_thr,
  input  logic [7:0]     black_thr,
  input  logic [1:0]     phase_sel,
  input  logic [X_W-1:0] grab_x,
  input  logic [Y_W-1:0] grab_y,
  input  logic           rd_en,
  input  logic [3:0]     rd_addr,
  output logic [31:0]    rd_data
);
  localparam logic [PH_W-1:0] PH_MAX = '1;

  logic [X_W-1:0]   pos_x;
  logic [Y_W-1:0]   pos_y;
  logic             frame_start, in_win, non_black, grab_hit;
  logic [7:0]       px      [NCH];
  logic [7:0]       ch_min  [NCH];
  logic [7:0]       ch_max  [NCH];
  logic [CNT_W-1:0] ch_lo   [NCH];
  logic [CNT_W-1:0] ch_hi   [NCH];
  logic [7:0]       sh_min  [NCH];
  logic [7:0]       sh_max  [NCH];
  logic [CNT_W-1:0] sh_lo   [NCH];
  logic [CNT_W-1:0] sh_hi   [NCH];
  logic             hx_seen, vy_seen;
  logic [X_W-1:0]   hx_lo, hx_hi, sh_hbp, sh_hact;
  logic [Y_W-1:0]   vy_lo, vy_hi, sh_vbp, sh_vact;
  logic [7:0]       ph_val, ph_prev, ph_diff;
  logic             ph_prev_ok;
  logic [PH_W-1:0]  ph_acc, ph_acc_d, sh_ph;
  logic [PH_W:0]    ph_sum;
  logic [23:0]      grab_acc, grab_d, sh_grab;
  logic             done_q, done_d;
  chan_sel_e        sel;

  calstat_timing #(.X_W(X_W), .Y_W(Y_W)) u_timing (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
    .pos_x(pos_x), .pos_y(pos_y), .frame_start(frame_start)
  );

  always_comb begin
    px[0]     = pix_r;
    px[1]     = pix_g;
    px[2]     = pix_b;
    in_win    = pix_de && pos_x >= win_x0 && pos_x <= win_x1 &&
                pos_y >= win_y0 && pos_y <= win_y1;
    non_black = pix_de && (pix_r > black_thr || pix_g > black_thr || pix_b > black_thr);
    grab_hit  = pix_de && pos_x == grab_x && pos_y == grab_y;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    calstat_chan #(.CNT_W(CNT_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .clr(frame_start), .take(in_win),
      .thr(hist_thr), .val(px[c]),
      .vmin(ch_min[c]), .vmax(ch_max[c]), .n_lo(ch_lo[c]), .n_hi(ch_hi[c])
    );
  end

  calstat_extent #(.W(X_W)) u_hext (
    .clk(clk), .rst_n(rst_n), .clr(frame_start), .hit(non_black), .pos(pos_x),
    .seen(hx_seen), .lo(hx_lo), .hi(hx_hi)
  );
  calstat_extent #(.W(Y_W)) u_vext (
    .clk(clk), .rst_n(rst_n), .clr(frame_start), .hit(non_black), .pos(pos_y),
    .seen(vy_seen), .lo(vy_lo), .hi(vy_hi)
  );

  // phase sum, grab and done next-state
  always_comb begin
    sel = chan_sel_e'(phase_sel);
    unique case (sel)
      CH_RED:  ph_val = pix_r;
      CH_GRN:  ph_val = pix_g;
      default: ph_val = pix_b;
    endcase
    ph_diff = (ph_val > ph_prev) ? ph_val - ph_prev : ph_prev - ph_val;
    ph_sum  = {1'b0, ph_acc} + (PH_W+1)'(ph_diff);
    if (frame_start)              ph_acc_d = '0;
    else if (in_win && ph_prev_ok) ph_acc_d = ph_sum[PH_W] ? PH_MAX : ph_sum[PH_W-1:0];
    else                          ph_acc_d = ph_acc;
    if (frame_start)   grab_d = '0;
    else if (grab_hit) grab_d = {pix_b, pix_g, pix_r};
    else               grab_d = grab_acc;
    if (frame_start)                          done_d = 1'b1;
    else if (rd_en && rd_addr == RA_STATUS)   done_d = 1'b0;
    else                                      done_d = done_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_acc     <= '0;
      ph_prev    <= '0;
      ph_prev_ok <= 1'b0;
      grab_acc   <= '0;
      done_q     <= 1'b0;
    end else begin
      ph_acc     <= ph_acc_d;
      ph_prev    <= ph_val;
      ph_prev_ok <= in_win;
      grab_acc   <= grab_d;
      done_q     <= done_d;
    end
  end

  // read-side copy, loaded once per frame
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        sh_min[c] <= '0;
        sh_max[c] <= '0;
        sh_lo[c]  <= '0;
        sh_hi[c]  <= '0;
      end
      sh_grab <= '0;
      sh_ph   <= '0;
      sh_hbp  <= '0;
      sh_hact <= '0;
      sh_vbp  <= '0;
      sh_vact <= '0;
    end else if (frame_start) begin
      for (int c = 0; c < NCH; c++) begin
        sh_min[c] <= ch_min[c];
        sh_max[c] <= ch_max[c];
        sh_lo[c]  <= ch_lo[c];
        sh_hi[c]  <= ch_hi[c];
      end
      sh_grab <= grab_acc;
      sh_ph   <= ph_acc;
      sh_hbp  <= hx_seen ? hx_lo : '0;
      sh_hact <= hx_seen ? hx_hi - hx_lo + X_W'(1) : '0;
      sh_vbp  <= vy_seen ? vy_lo : '0;
      sh_vact <= vy_seen ? vy_hi - vy_lo + Y_W'(1) : '0;
    end
  end

  always_comb begin
    unique case (rd_addr)
      RA_STATUS: rd_data = {31'd0, done_q};
      RA_MIN:    rd_data = {8'd0, sh_min[2], sh_min[1], sh_min[0]};
      RA_MAX:    rd_data = {8'd0, sh_max[2], sh_max[1], sh_max[0]};
      RA_RLO:    rd_data = 32'(sh_lo[0]);
      RA_RHI:    rd_data = 32'(sh_hi[0]);
      RA_GLO:    rd_data = 32'(sh_lo[1]);
      RA_GHI:    rd_data = 32'(sh_hi[1]);
      RA_BLO:    rd_data = 32'(sh_lo[2]);
      RA_BHI:    rd_data = 32'(sh_hi[2]);
      RA_GRAB:   rd_data = {8'd0, sh_grab};
      RA_PHASE:  rd_data = 32'(sh_ph);
      RA_HBP:    rd_data = 32'(sh_hbp);
      RA_HACT:   rd_data = 32'(sh_hact);
      RA_VBP:    rd_data = 32'(sh_vbp);
      RA_VACT:   rd_data = 32'(sh_vact);
      default:   rd_data = 32'd0;
    endcase
  end
endmodule

// File: rtl/calstat_chk.sv
module calstat_chk #(
  parameter int X_W   = 12,
  parameter int Y_W   = 12,
  parameter int CNT_W = 20,
  parameter int PH_W  = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_start,
  input logic             in_win,
  input logic             grab_hit,
  input logic             done_q,
  input logic             rd_en,
  input logic [3:0]       rd_addr,
  input logic [7:0]       mn0,
  input logic [7:0]       mx0,
  input logic [CNT_W-1:0] lo0,
  input logic [CNT_W-1:0] hi0,
  input logic [PH_W-1:0]  ph_acc,
  input logic [23:0]      grab_acc
);
  logic [CNT_W:0] cnt_sum;
  assign cnt_sum = {1'b0, lo0} + {1'b0, hi0};

  AST_DONE_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> done_q); // R10
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == 4'd0 && !frame_start) |=> !done_q); // R10
  AST_MIN_NOT_ABOVE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    (in_win && !frame_start) |=> mn0 <= mx0); // R1
  AST_ONE_COUNT_PER_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> cnt_sum <= $past(cnt_sum) + (CNT_W+1)'(1)); // R2
  AST_PHASE_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ph_acc >= $past(ph_acc)); // R8
  AST_GRAB_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_start && !grab_hit) |=> $stable(grab_acc)); // R3
  AST_FRAME_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (ph_acc == '0 && grab_acc == '0 && mn0 == 8'hFF && lo0 == '0)); // R9
endmodule

bind calstat_top calstat_chk #(.X_W(X_W), .Y_W(Y_W), .CNT_W(CNT_W), .PH_W(PH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .in_win(in_win),
  .grab_hit(grab_hit), .done_q(done_q), .rd_en(rd_en), .rd_addr(rd_addr),
  .mn0(ch_min[0]), .mx0(ch_max[0]), .lo0(ch_lo[0]), .hi0(ch_hi[0]),
  .ph_acc(ph_acc), .grab_acc(grab_acc)
);

// File: tb/tb_calstat_top.sv
`timescale 1ns/10ps
module tb_calstat_top;
  localparam int X_W = 12, Y_W = 12, CNT_W = 20, PH_W = 12;
  localparam int LINES = 14, LCYC = 32, HS_LEN = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic pix_de, hsync, vsync, rd_en;
  logic [7:0] pix_r, pix_g, pix_b, hist_thr, black_thr;
  logic [X_W-1:0] win_x0, win_x1, grab_x;
  logic [Y_W-1:0] win_y0, win_y1, grab_y;
  logic [1:0] phase_sel;
  logic [3:0] rd_addr;
  logic [31:0] rd_data;

  int n_chk = 0, n_fail = 0;
  logic [31:0] nxt [16];
  logic [31:0] cur [16];

  always #2.5 clk = ~clk;

  calstat_top #(.X_W(X_W), .Y_W(Y_W), .CNT_W(CNT_W), .PH_W(PH_W)) dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string tag_of(int a);
    case (a)
      1, 2:                 return "R1 R4 min/max";
      3, 4, 5, 6, 7, 8:     return "R2 histogram";
      9:                    return "R3 grab";
      10:                   return "R7 R8 phase";
      11, 12:               return "R5 horizontal";
      13, 14:               return "R6 vertical";
      default:              return "R12 map";
    endcase
  endfunction

  function automatic bit is_de(int x, int y);
    return x >= 6 && x <= 21 && y >= 2 && y <= 9;
  endfunction

  function automatic logic [7:0] pv(int s, int x, int y, int ch);
    if (x >= 8 && x <= 19 && y >= 3 && y <= 8)
      return 8'(16 + ((x * 37 + y * 11 + s * 5 + ch * 53) % 200));
    return 8'd0;
  endfunction

  // expected results from the requirements, for the frame about to run
  task automatic compute(int s);
    int mn[3], mx[3], lo[3], hi[3];
    int ph, hmin, hmax, vmin, vmax, chs;
    logic [23:0] grab;
    bit seen;
    for (int c = 0; c < 3; c++) begin mn[c] = 255; mx[c] = 0; lo[c] = 0; hi[c] = 0; end
    ph = 0; grab = '0; seen = 0; hmin = 0; hmax = 0; vmin = 0; vmax = 0;
    chs = (phase_sel == 2'd0) ? 0 : (phase_sel == 2'd1) ? 1 : 2;
    for (int y = 0; y < LINES - 2; y++) begin
      bit pok = 0;
      int prev = 0;
      for (int x = 0; x < LCYC - HS_LEN; x++) begin
        bit w;
        int v;
        if (!is_de(x, y)) begin pok = 0; continue; end  // R4: de low ignored
        w = x >= int'(win_x0) && x <= int'(win_x1) && y >= int'(win_y0) && y <= int'(win_y1);
        if (w) begin
          for (int c = 0; c < 3; c++) begin
            v = pv(s, x, y, c);
            if (v < mn[c]) mn[c] = v;
            if (v > mx[c]) mx[c] = v;
            if (v < int'(hist_thr)) lo[c]++;
            if (v > int'(hist_thr)) hi[c]++;
          end
          v = pv(s, x, y, chs);
          if (pok) ph += (v > prev) ? v - prev : prev - v;
          prev = v; pok = 1;
        end else pok = 0;
        if (x == int'(grab_x) && y == int'(grab_y))
          grab = {pv(s, x, y, 2), pv(s, x, y, 1), pv(s, x, y, 0)};
        if (pv(s, x, y, 0) > black_thr || pv(s, x, y, 1) > black_thr || pv(s, x, y, 2) > black_thr) begin
          if (!seen) begin hmin = x; hmax = x; vmin = y; vmax = y; seen = 1; end
          if (x < hmin) hmin = x;
          if (x > hmax) hmax = x;
          if (y < vmin) vmin = y;
          if (y > vmax) vmax = y;
        end
      end
    end
    if (ph > (1 << PH_W) - 1) ph = (1 << PH_W) - 1;
    nxt[0]  = 32'd1;
    nxt[1]  = {8'd0, 8'(mn[2]), 8'(mn[1]), 8'(mn[0])};
    nxt[2]  = {8'd0, 8'(mx[2]), 8'(mx[1]), 8'(mx[0])};
    for (int c = 0; c < 3; c++) begin nxt[3 + 2 * c] = 32'(lo[c]); nxt[4 + 2 * c] = 32'(hi[c]); end
    nxt[9]  = {8'd0, grab};
    nxt[10] = 32'(ph);
    nxt[11] = seen ? 32'(hmin) : 32'd0;
    nxt[12] = seen ? 32'(hmax + 1 - hmin) : 32'd0;
    nxt[13] = seen ? 32'(vmin) : 32'd0;
    nxt[14] = seen ? 32'(vmax + 1 - vmin) : 32'd0;
    nxt[15] = 32'd0;
  endtask

  task automatic check_all();
    for (int a = 1; a < 16; a++) begin
      rd_addr = 4'(a);
      #0.2;
      chk(tag_of(a), rd_data, cur[a]);
    end
  endtask

  task automatic run_frame(int s, bit do_check);
    for (int l = 0; l < LINES; l++) begin
      for (int c = 0; c < LCYC; c++) begin
        int x, y;
        @(posedge clk); #1;
        x = c - HS_LEN; y = l - 2;
        hsync = c < HS_LEN;
        vsync = l < 2;
        if (c >= HS_LEN && l >= 2 && is_de(x, y)) begin
          pix_de = 1'b1;
          pix_r = pv(s, x, y, 0); pix_g = pv(s, x, y, 1); pix_b = pv(s, x, y, 2);
        end else begin
          pix_de = 1'b0;
          pix_r = 8'hEE; pix_g = 8'hEE; pix_b = 8'hEE;
        end
        if (do_check) begin
          if (l == 6 && c == 0) check_all();
          if (l == 10 && c == 0) begin
            rd_addr = 4'd0; #0.2;
            chk("R10 done set", rd_data, 32'd1);
            rd_en = 1'b1;
          end
          if (l == 10 && c == 1) begin
            rd_en = 1'b0; #0.2;
            chk("R10 done cleared", rd_data, 32'd0);
          end
          if (l == 12 && c == 0) begin
            rd_addr = 4'd10; #0.2;
            chk("R9 phase held during frame", rd_data, cur[10]);
            rd_addr = 4'd1; #0.2;
            chk("R9 min held during frame", rd_data, cur[1]);
          end
        end
      end
    end
  endtask

  task automatic config_frame(int x0, int x1, int y0, int y1, int thr, int sel, int gx, int gy, int s);
    win_x0 = X_W'(x0); win_x1 = X_W'(x1); win_y0 = Y_W'(y0); win_y1 = Y_W'(y1);
    hist_thr = 8'(thr); phase_sel = 2'(sel); grab_x = X_W'(gx); grab_y = Y_W'(gy);
    compute(s);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pix_de = 1'b0; hsync = 1'b0; vsync = 1'b0; rd_en = 1'b0; rd_addr = '0;
    pix_r = '0; pix_g = '0; pix_b = '0; black_thr = 8'd10;
    win_x0 = '0; win_x1 = '0; win_y0 = '0; win_y1 = '0; hist_thr = '0; phase_sel = '0;
    grab_x = '0; grab_y = '0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    for (int a = 0; a < 16; a++) begin
      rd_addr = 4'(a);
      #0.2;
      chk("R11 R12 reset value", rd_data, 32'd0);
    end
    // full window, phase saturates (R8), grab inside picture
    config_frame(0, 27, 0, 11, 100, 0, 10, 4, 1);
    run_frame(1, 1'b0);
    cur = nxt;
    // narrow window on green, grab inside
    config_frame(9, 15, 4, 6, 128, 1, 12, 5, 2);
    run_frame(2, 1'b1);
    cur = nxt;
    // empty window, grab never hit
    config_frame(20, 10, 0, 11, 50, 2, 0, 0, 3);
    run_frame(3, 1'b1);
    cur = nxt;
    // black pixels equal to level 0 count in neither bin
    config_frame(6, 21, 2, 9, 0, 3, 21, 9, 4);
    run_frame(4, 1'b1);
    cur = nxt;
    // window edge columns only
    config_frame(8, 9, 3, 3, 120, 0, 19, 8, 5);
    run_frame(5, 1'b1);
    cur = nxt;
    config_frame(0, 27, 0, 11, 100, 0, 0, 0, 6);
    run_frame(6, 1'b1);
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule